// File: doc/BRIEF.md
# Prioritized Stall Cycle Accounting Unit

This block gives every back-end clock cycle of a pipelined processor a single cause. Each cycle it samples six condition flags, one per stall or flush cause. A cycle with no flag raised is useful execution. A cycle with one or more flags raised is charged to exactly one cause, picked by a fixed priority. Causes that arise later in the pipe win over overlapping delays from earlier stages, so time lost to overlapping delays is never counted twice.

Alongside the charged counters, the block keeps a total-cycle counter. It also keeps a plain duration counter per cause. A duration counter advances on every cycle its own flag is high, whatever else is active, and so gives the cumulative latency of that cause. All counters saturate. They are zeroed together by a synchronous clear strobe and are read through a registered index port.

Top module: `cycle_attrib_unit`

## Requirements
- R1: Each clock cycle with the clear strobe low and reset released adds one to the total-cycle counter (read index 0).
- R2: A counted cycle with all six flags low adds one to the execution counter (read index 1).
- R3: A counted cycle with at least one flag high adds one to the charged counter of the highest-priority high flag only. The flag bits map as follows: bit 0 is exception/interrupt flush, bit 1 is branch-mispredict flush, bit 2 is data/FPU access stall, bit 3 is execution-latency stall, bit 4 is register-stack spill/fill stall, and bit 5 is front-end starvation. Priority runs from bit 0 (highest) to bit 5 (lowest). The charged counter for bit i is at read index 2+i.
- R4: While no counter has saturated, the execution counter plus the six charged counters equals the total-cycle counter.
- R5: The duration counter for flag bit i (read index 8+i) adds one on every counted cycle in which bit i is high, independent of the other flags.
- R6: A cycle with the clear strobe high zeroes every counter, and that cycle itself is counted nowhere.
- R7: Every counter holds at its all-ones value instead of wrapping (CNT_W bits wide, 32 by default).
- R8: The read data is the value of the counter selected by the index one clock earlier, as it stood before that edge's update. Indices 14 and 15 read as zero.
- R9: While reset is held, every counter and the read data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| clearStrobe | input | 1 | Zeroes all counters; the cycle is not counted |
| reasonFlags | input | 6 | One condition flag per stall/flush cause, bit 0 highest priority |
| rdIndex | input | 4 | Counter select for the read port |
| rdData | output | CNT_W (32) | Selected counter value, registered |

## Verification
A wrong priority decode shows up as a charged counter that drifts from the bench's model in the cycle after the overlap. It appears at the next read of that index, and as a break in the sum relation against the total counter. A duration counter wired to the winner instead of the raw flag diverges on the first overlapping cycle. A counter that wraps instead of holding shows zero one read after its all-ones value. A clear that is itself counted leaves the total at one instead of zero on the very next read.

// File: rtl/cyc_acct_pkg.sv
package cyc_acct_pkg;
  localparam int NUM_REASONS = 6;
  localparam int NUM_CNT = 2 + 2 * NUM_REASONS;

  typedef struct packed {
    logic                   clr;
    logic                   tick;
    logic                   execInc;
    logic [NUM_REASONS-1:0] winner;
    logic [NUM_REASONS-1:0] rawInc;
  } acctStrobes_t;
endpackage

// File: rtl/cyc_sat_counter.sv
module cyc_sat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] MAX_VAL = '1;

  always_ff @(posedge clk) begin
    if (!rstN || clr) begin
      count <= '0;
    end else if (inc && count != MAX_VAL) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/cyc_acct_ctrl.sv
module cyc_acct_ctrl
  import cyc_acct_pkg::*;
(
  input  logic                   clearStrobe,
  input  logic [NUM_REASONS-1:0] reasonFlags,
  output acctStrobes_t           strobes
);
  logic [NUM_REASONS-1:0] prioPick;

  always_comb begin
    logic taken;
    taken = 1'b0;
    prioPick = '0;
    for (int i = 0; i < NUM_REASONS; i++) begin
      if (reasonFlags[i] && !taken) begin
        prioPick[i] = 1'b1;
        taken = 1'b1;
      end
    end
  end

  always_comb begin
    strobes.clr     = clearStrobe;
    strobes.tick    = !clearStrobe;
    strobes.execInc = !clearStrobe && (reasonFlags == '0);
    strobes.winner  = clearStrobe ? '0 : prioPick;
    strobes.rawInc  = clearStrobe ? '0 : reasonFlags;
  end
endmodule

// File: rtl/cyc_acct_dp.sv
module cyc_acct_dp
  import cyc_acct_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  acctStrobes_t     strobes,
  input  logic [IDX_W-1:0] rdIndex,
  output logic [CNT_W-1:0] rdData,
  output logic [CNT_W-1:0] totalCnt,
  output logic [CNT_W-1:0] execCnt
);
  logic [NUM_CNT-1:0] incVec;
  logic [CNT_W-1:0]   cnt [NUM_CNT];

  assign incVec = {strobes.rawInc, strobes.winner, strobes.execInc, strobes.tick};

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    cyc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk  (clk),
      .rstN (rstN),
      .clr  (strobes.clr),
      .inc  (incVec[g]),
      .count(cnt[g])
    );
  end

  assign totalCnt = cnt[0];
  assign execCnt  = cnt[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (int'(rdIndex) < NUM_CNT) begin
      rdData <= cnt[rdIndex];
    end else begin
      rdData <= '0;
    end
  end
endmodule

// File: rtl/cycle_attrib_unit.sv
module cycle_attrib_unit
  import cyc_acct_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clearStrobe,
  input  logic [5:0]       reasonFlags,
  input  logic [3:0]       rdIndex,
  output logic [CNT_W-1:0] rdData
);
  acctStrobes_t     strobes;
  logic [CNT_W-1:0] totalCnt;
  logic [CNT_W-1:0] execCnt;

  cyc_acct_ctrl u_ctrl (
    .clearStrobe(clearStrobe),
    .reasonFlags(reasonFlags),
    .strobes    (strobes)
  );

  cyc_acct_dp #(.CNT_W(CNT_W), .IDX_W(4)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .rdIndex (rdIndex),
    .rdData  (rdData),
    .totalCnt(totalCnt),
    .execCnt (execCnt)
  );
endmodule

// File: rtl/cyc_acct_chk.sv
module cyc_acct_chk
  import cyc_acct_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             clearStrobe,
  input logic [5:0]       reasonFlags,
  input acctStrobes_t     strobes,
  input logic [CNT_W-1:0] totalCnt,
  input logic [CNT_W-1:0] execCnt
);
  localparam logic [CNT_W-1:0] MAX_VAL = '1;

  p_one_category_r4: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobes.execInc, strobes.winner}) == (clearStrobe ? 0 : 1));

  p_exception_wins_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reasonFlags[0] && !clearStrobe) |-> (strobes.winner == 6'b000001));

  p_idle_is_exec_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reasonFlags == 6'b0 && !clearStrobe) |-> (strobes.execInc && strobes.winner == 6'b0));

  p_clear_zeroes_r6: assert property (@(posedge clk) disable iff (!rstN)
    clearStrobe |=> (totalCnt == '0 && execCnt == '0));

  p_total_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!clearStrobe && totalCnt != MAX_VAL) |=> (totalCnt == $past(totalCnt) + 1'b1));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!clearStrobe && totalCnt == MAX_VAL) |=> (totalCnt == MAX_VAL));
endmodule

bind cycle_attrib_unit cyc_acct_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .clearStrobe(clearStrobe),
  .reasonFlags(reasonFlags),
  .strobes    (strobes),
  .totalCnt   (totalCnt),
  .execCnt    (execCnt)
);

// File: tb/cycle_attrib_unit_tb.sv
module cycle_attrib_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 10;
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             clearStrobe = 1'b0;
  logic [5:0]       reasonFlags = 6'b0;
  logic [3:0]       rdIndex = 4'd0;
  logic [CNT_W-1:0] rdData;

  int vecCount = 0;
  int failCount = 0;
  bit finished = 1'b0;
  logic [CNT_W-1:0] model [14];

  always #(CLK_PERIOD/2) clk = ~clk;

  cycle_attrib_unit #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .clearStrobe(clearStrobe),
    .reasonFlags(reasonFlags), .rdIndex(rdIndex), .rdData(rdData)
  );

  function automatic int pickFirst(input logic [5:0] f);
    for (int i = 0; i < 6; i++) if (f[i]) return i;
    return -1;
  endfunction

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return (v == MAXV) ? v : v + 1'b1;
  endfunction

  function automatic string tagOf(input logic [3:0] ix);
    if (ix == 0) return "R1";
    if (ix == 1) return "R2";
    if (ix < 8) return "R3";
    if (ix < 14) return "R5";
    return "R8";
  endfunction

  task automatic check(input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] exp, input string tag);
    vecCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic modelUpdate(input logic [5:0] f, input logic c);
    int w;
    if (c) begin
      for (int i = 0; i < 14; i++) model[i] = '0;
    end else begin
      model[0] = bump(model[0]);
      w = pickFirst(f);
      if (w < 0) model[1] = bump(model[1]);
      else model[2+w] = bump(model[2+w]);
      for (int i = 0; i < 6; i++) if (f[i]) model[8+i] = bump(model[8+i]);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge after checking.
  task automatic doCycle(input logic [5:0] f, input logic c, input logic [3:0] ix,
                         output logic [CNT_W-1:0] got);
    logic [CNT_W-1:0] exp;
    reasonFlags = f; clearStrobe = c; rdIndex = ix;
    exp = (ix < 14) ? model[ix] : '0;
    modelUpdate(f, c);
    @(negedge clk);
    got = rdData;
    check(rdData, exp, tagOf(ix));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  end

  initial begin : stim
    logic [CNT_W-1:0] got;
    logic [CNT_W-1:0] vals [8];
    logic [CNT_W-1:0] sum;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 14; i++) model[i] = '0;

    // R9: reset state
    repeat (3) @(negedge clk);
    check(rdData, '0, "R9");
    rstN = 1'b1;

    // R8: every index right after reset reads zero
    for (int i = 0; i < 16; i++) doCycle(6'b0, 1'b0, 4'(i), got);

    // R3: all flags overlap; only exception charged
    doCycle(6'h3F, 1'b0, 4'd2, got);
    doCycle(6'b0, 1'b0, 4'd2, got);
    check(got, model[2], "R3 exception wins");
    doCycle(6'b0, 1'b0, 4'd3, got);
    // R5: all duration counters moved on the overlap cycle
    doCycle(6'b0, 1'b0, 4'd13, got);
    check(got, 10'd1, "R5 raw front-end");
    // R3: branch vs front-end overlap
    doCycle(6'b100010, 1'b0, 4'd7, got);
    doCycle(6'b0, 1'b0, 4'd7, got);
    check(got, 10'd0, "R3 front-end loses");
    doCycle(6'b0, 1'b0, 4'd3, got);
    check(got, 10'd1, "R3 branch charged");

    // R6: clear zeroes and is not counted
    doCycle(6'h3F, 1'b1, 4'd0, got);
    doCycle(6'b0, 1'b0, 4'd0, got);
    check(got, 10'd0, "R6 total after clear");
    doCycle(6'b0, 1'b0, 4'd8, got);
    check(got, 10'd0, "R6 raw after clear");

    // random mix
    for (int n = 0; n < 900; n++) begin
      logic [5:0] f;
      f = (($urandom % 4) == 0) ? 6'b0 : 6'($urandom);
      doCycle(f, (($urandom % 300) == 0), 4'($urandom % 16), got);
    end

    // R4: with idle flags, sum of categories equals total
    doCycle(6'b0, 1'b1, 4'd0, got);
    for (int n = 0; n < 300; n++) doCycle(6'($urandom), 1'b0, 4'd0, got);
    for (int i = 0; i < 8; i++) doCycle(6'b0, 1'b0, 4'(i), vals[i]);
    sum = vals[1] - 1'b1;
    for (int i = 2; i < 8; i++) sum = sum + vals[i];
    check(vals[0], sum, "R4 sum equals total");

    // R7: saturation
    doCycle(6'b0, 1'b1, 4'd0, got);
    for (int n = 0; n < 1100; n++) doCycle(6'b010000, 1'b0, 4'd6, got);
    check(got, MAXV, "R7 charged holds");
    doCycle(6'b010000, 1'b0, 4'd0, got);
    doCycle(6'b010000, 1'b0, 4'd12, got);
    check(got, MAXV, "R7 raw holds");
    doCycle(6'b0, 1'b0, 4'd0, got);
    check(got, MAXV, "R7 total holds");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end
endmodule